// File: doc/BRIEF.md
# DMA channel address and count registers

This block keeps the addressing and counting state of a single DMA channel. It holds a source pointer, a destination pointer and a transfer counter with a shadow reload register. Software programs these through a small register port. A separate control port sets the channel enable, a direction bit for each pointer (fixed or forward), a repeat-mode bit and the transfer unit size.

While the channel is enabled, each transfer strobe from the bus engine advances every forward pointer by the unit size and counts the counter down. A strobe that finds the counter at zero is an underflow, and it raises a one-cycle done pulse. In single-shot mode the underflow also turns the channel off. In repeat mode the channel stays enabled, the counter is reloaded and the working pointers are restored. The address outputs drive the bus engine.

Top module: `dma_chan_regs`

## Requirements
- R1: Register select codes are 0 for source, 1 for destination, 2 for counter, and 3 for none. Code 3 ignores writes and reads as zero. Pointers keep bits 19:0 of a write. Pointer reads return zero in bits 23:20. Counter reads return zero in bits 23:16, and a counter write keeps bits 15:0 only.
- R2: A pointer whose direction bit is 0 (fixed) accepts a write only while the channel is disabled. A write made while the channel is enabled leaves its read-back value and address output unchanged.
- R3: A pointer whose direction bit is 1 (forward) accepts a write at any time. While the channel is enabled, that write does not disturb the working pointer currently in use.
- R4: A pointer read, and its address output, returns the working pointer when its direction bit is 1 and the channel is enabled. Otherwise it returns the last value written.
- R5: A counter write stores into the reload register only. Reading the counter returns the live count.
- R6: A control write that takes the enable from 0 to 1 does two things on that edge. It copies the reload register into the live count, and it copies each written pointer value into its working pointer.
- R7: A strobe while enabled decrements the count by one, wrapping 0000h to FFFFh. It also increments each forward working pointer by the unit: 2 when the control wide bit is 1, otherwise 1. A fixed pointer holds its value.
- R8: Forward pointers wrap modulo 2^20.
- R9: A strobe at count 0 in single-shot mode (repeat bit 0) raises the done output for exactly the next cycle and clears the enable.
- R10: A strobe at count 0 in repeat mode raises the same done pulse but leaves the channel enabled. It reloads the count from the reload register and restores each working pointer from its written value.
- R11: A strobe has no effect when the channel is disabled, or when it arrives in the same cycle as a control write.
- R12: After reset the enable, the direction bits, the mode bits and the done output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 source, 1 destination, 2 counter, 3 none |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Read-back of the selected register |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Channel enable value |
| ctl_src_fwd | input | 1 | Source direction: 1 forward, 0 fixed |
| ctl_dst_fwd | input | 1 | Destination direction: 1 forward, 0 fixed |
| ctl_repeat | input | 1 | 1 repeat mode, 0 single-shot |
| ctl_wide | input | 1 | Transfer unit: 1 two bytes, 0 one byte |
| xfer_strobe | input | 1 | One transfer completed |
| chan_en | output | 1 | Current channel enable |
| done | output | 1 | One-cycle pulse on counter underflow |
| src_addr | output | 20 | Source address in use |
| dst_addr | output | 20 | Destination address in use |

## Verification
The assertions check several rules on every cycle. Fixed pointers must be locked while the channel is enabled. An enable or a reload must copy the shadow values. Counter writes must leave the live count alone. Each underflow must produce the right enable state with its done pulse. The bench's scenarios cover what needs a programmed history: read-back switching between the written and working pointers, wrap at the top of the 20-bit space, two-byte stepping, and strobes being ignored while disabled or when they collide with a control write.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
   typedef enum logic [1:0] {
      SEL_SRC  = 2'd0,
      SEL_DST  = 2'd1,
      SEL_CNT  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic en;
      logic src_fwd;
      logic dst_fwd;
      logic rpt;
      logic wide;
   } chan_ctl_t;
endpackage

// File: rtl/dma_ptr.sv
module dma_ptr #(
   parameter int ADDR_W = 20,
   parameter int REG_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              fwd,
   input  logic              en,
   input  logic [REG_W-1:0]  wdata,
   input  logic              load,
   input  logic              step,
   input  logic [1:0]        inc,
   output logic [REG_W-1:0]  rdata,
   output logic [ADDR_W-1:0] addr
);
   localparam int PAD_W = REG_W - ADDR_W;

   logic [ADDR_W-1:0] prog_q;
   logic [ADDR_W-1:0] work_q;
   logic              accept;

   assign accept = wr && (fwd || !en);

   always_ff @(posedge clk) begin
      if (accept) prog_q <= wdata[ADDR_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (load)              work_q <= prog_q;
      else if (step && fwd)  work_q <= work_q + ADDR_W'(inc);
   end

   assign addr  = (fwd && en) ? work_q : prog_q;
   assign rdata = {{PAD_W{1'b0}}, addr};

   // R2: a fixed pointer is locked while the channel runs
   a_r2_fixed_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !fwd && en) |=> $stable(prog_q));

   // R6: enable or repeat reload restores the working copy
   a_r6_work_restore: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (work_q == $past(prog_q)));
endmodule

// File: rtl/dma_cnt.sv
module dma_cnt #(
   parameter int CNT_W = 16,
   parameter int REG_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             load,
   input  logic             step,
   input  logic             rpt,
   output logic [CNT_W-1:0] count,
   output logic             underflow
);
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] count_q;

   assign underflow = step && (count_q == '0);

   always_ff @(posedge clk) begin
      if (wr) reload_q <= wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (load || (underflow && rpt)) count_q <= reload_q;
      else if (step)                  count_q <= count_q - 1'b1;
   end

   assign count = count_q;

   // R5: a counter write only touches the shadow register
   a_r5_shadow_only: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !load && !step) |=> $stable(count_q));

   // R6: enabling copies the shadow into the live count
   a_r6_enable_reload: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (count_q == $past(reload_q)));

   // R7: ordinary strobes count down by one
   a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && (count_q != '0)) |=> (count_q == $past(count_q) - 1'b1));

   // R10: repeat underflow refills the counter
   a_r10_repeat_refill: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow && rpt && !load) |=> (count_q == $past(reload_q)));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_chan_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int REG_W     = 24,
   parameter int CNT_W     = 16,
   parameter bit WIDE_UNIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              ctl_wr,
   input  logic              ctl_en,
   input  logic              ctl_src_fwd,
   input  logic              ctl_dst_fwd,
   input  logic              ctl_repeat,
   input  logic              ctl_wide,
   input  logic              xfer_strobe,
   output logic              chan_en,
   output logic              done,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr
);
   localparam int NPTR  = 2;
   localparam int CPAD  = REG_W - CNT_W;

   if (ADDR_W > REG_W) begin : g_bad_addr
      $error("ADDR_W must not exceed REG_W");
   end
   if (CNT_W > REG_W) begin : g_bad_cnt
      $error("CNT_W must not exceed REG_W");
   end

   chan_ctl_t        ctl_q;
   logic             done_q;
   logic             start;
   logic             step;
   logic             uf;
   logic             ptr_load;
   logic [1:0]       inc;
   logic [CNT_W-1:0] cnt_val;
   reg_sel_e         sel;

   logic [NPTR-1:0]   ptr_fwd;
   logic [NPTR-1:0]   ptr_wr;
   logic [REG_W-1:0]  ptr_rdata [NPTR];
   logic [ADDR_W-1:0] ptr_addr  [NPTR];

   assign sel      = reg_sel_e'(reg_sel);
   assign start    = ctl_wr && ctl_en && !ctl_q.en;
   assign step     = xfer_strobe && ctl_q.en && !ctl_wr;
   assign ptr_load = start || (uf && ctl_q.rpt);

   if (WIDE_UNIT) begin : g_unit_var
      assign inc = ctl_q.wide ? 2'd2 : 2'd1;
   end else begin : g_unit_byte
      assign inc = 2'd1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= uf;
         if (ctl_wr) begin
            ctl_q.en      <= ctl_en;
            ctl_q.src_fwd <= ctl_src_fwd;
            ctl_q.dst_fwd <= ctl_dst_fwd;
            ctl_q.rpt     <= ctl_repeat;
            ctl_q.wide    <= ctl_wide;
         end else if (uf && !ctl_q.rpt) begin
            ctl_q.en      <= 1'b0;
         end
      end
   end

   assign ptr_fwd = {ctl_q.dst_fwd, ctl_q.src_fwd};

   for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      assign ptr_wr[g] = reg_wr && (reg_sel == 2'(g));
      dma_ptr #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_ptr (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (ptr_wr[g]),
         .fwd   (ptr_fwd[g]),
         .en    (ctl_q.en),
         .wdata (reg_wdata),
         .load  (ptr_load),
         .step  (step),
         .inc   (inc),
         .rdata (ptr_rdata[g]),
         .addr  (ptr_addr[g])
      );
   end

   dma_cnt #(.CNT_W(CNT_W), .REG_W(REG_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr && (sel == SEL_CNT)),
      .wdata     (reg_wdata),
      .load      (start),
      .step      (step),
      .rpt       (ctl_q.rpt),
      .count     (cnt_val),
      .underflow (uf)
   );

   always_comb begin
      unique case (sel)
         SEL_SRC: reg_rdata = ptr_rdata[0];
         SEL_DST: reg_rdata = ptr_rdata[1];
         SEL_CNT: reg_rdata = {{CPAD{1'b0}}, cnt_val};
         default: reg_rdata = '0;
      endcase
   end

   assign chan_en  = ctl_q.en;
   assign done     = done_q;
   assign src_addr = ptr_addr[0];
   assign dst_addr = ptr_addr[1];

   // R9: single-shot underflow stops the channel with a pulse
   a_r9_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (step && (cnt_val == '0) && !ctl_q.rpt) |=> (!chan_en && done));

   // R10: repeat underflow keeps running with a pulse
   a_r10_repeat_run: assert property (@(posedge clk) disable iff (!rst_n)
      (step && (cnt_val == '0) && ctl_q.rpt) |=> (chan_en && done));

   // R11: no done pulse can follow an idle cycle
   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!chan_en || ctl_wr) |=> !done);
endmodule

// File: tb/dma_chan_regs_bench.sv
`timescale 1ns/1ps
module dma_chan_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [23:0] reg_wdata = '0;
   logic [23:0] reg_rdata;
   logic        ctl_wr = 1'b0, ctl_en = 1'b0, ctl_src_fwd = 1'b0;
   logic        ctl_dst_fwd = 1'b0, ctl_repeat = 1'b0, ctl_wide = 1'b0;
   logic        xfer_strobe = 1'b0;
   logic        chan_en, done;
   logic [19:0] src_addr, dst_addr;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   dma_chan_regs u_dma_chan_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_wr(ctl_wr),
      .ctl_en(ctl_en), .ctl_src_fwd(ctl_src_fwd), .ctl_dst_fwd(ctl_dst_fwd),
      .ctl_repeat(ctl_repeat), .ctl_wide(ctl_wide), .xfer_strobe(xfer_strobe),
      .chan_en(chan_en), .done(done), .src_addr(src_addr), .dst_addr(dst_addr)
   );

   // behavioural reference model
   int m_en, m_sf, m_df, m_rp, m_wd, m_done, m_init;
   int m_sp, m_dp, m_sw, m_dw, m_rld, m_cnt;

   always @(posedge clk) begin
      int stp, uf, st, inc, n_sp, n_dp, n_sw, n_dw, n_rld, n_cnt;
      if (!rst_n) begin
         m_en = 0; m_sf = 0; m_df = 0; m_rp = 0; m_wd = 0; m_done = 0;
      end else begin
         stp = (xfer_strobe && m_en && !ctl_wr) ? 1 : 0;
         uf  = (stp && m_cnt == 0) ? 1 : 0;
         st  = (ctl_wr && ctl_en && !m_en) ? 1 : 0;
         inc = m_wd ? 2 : 1;
         n_sp = m_sp; n_dp = m_dp; n_sw = m_sw; n_dw = m_dw;
         n_rld = m_rld; n_cnt = m_cnt;
         if (reg_wr && reg_sel == 2'd0 && (m_sf || !m_en)) n_sp = reg_wdata & 24'hFFFFF;
         if (reg_wr && reg_sel == 2'd1 && (m_df || !m_en)) n_dp = reg_wdata & 24'hFFFFF;
         if (reg_wr && reg_sel == 2'd2) n_rld = reg_wdata & 24'hFFFF;
         if (st || (uf && m_rp)) begin
            n_sw = m_sp; n_dw = m_dp; n_cnt = m_rld;
         end else if (stp) begin
            if (m_sf) n_sw = (m_sw + inc) % 1048576;
            if (m_df) n_dw = (m_dw + inc) % 1048576;
            n_cnt = (m_cnt + 65535) % 65536;
         end
         if (st) m_init = 1;
         m_done = uf;
         if (ctl_wr) begin
            m_en = ctl_en; m_sf = ctl_src_fwd; m_df = ctl_dst_fwd;
            m_rp = ctl_repeat; m_wd = ctl_wide;
         end else if (uf && !m_rp) m_en = 0;
         m_sp = n_sp; m_dp = n_dp; m_sw = n_sw; m_dw = n_dw;
         m_rld = n_rld; m_cnt = n_cnt;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      int es, ed, er;
      if (rst_n && !finished) begin
         chk("R9 chan_en", chan_en, m_en);
         chk("R9 done", done, m_done);
         if (m_init) begin
            es = (m_sf && m_en) ? m_sw : m_sp;
            ed = (m_df && m_en) ? m_dw : m_dp;
            er = (reg_sel == 2'd0) ? es : (reg_sel == 2'd1) ? ed :
                 (reg_sel == 2'd2) ? m_cnt : 0;
            chk("R7 src_addr", src_addr, es);
            chk("R7 dst_addr", dst_addr, ed);
            chk("R4 reg_rdata", reg_rdata, er);
         end
      end
   end

   task automatic wreg(input logic [1:0] s, input logic [23:0] d);
      reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); #1 reg_wr = 1'b0;
   endtask

   task automatic ctl(input logic e, sf, df, rp, wd, input logic xs);
      ctl_en = e; ctl_src_fwd = sf; ctl_dst_fwd = df; ctl_repeat = rp;
      ctl_wide = wd; ctl_wr = 1'b1; xfer_strobe = xs;
      @(negedge clk); #1 ctl_wr = 1'b0; xfer_strobe = 1'b0;
   endtask

   task automatic strobe(input int n);
      for (int i = 0; i < n; i++) begin
         xfer_strobe = 1'b1;
         @(negedge clk); #1 xfer_strobe = 1'b0;
      end
   endtask

   task automatic rd(input logic [1:0] s, output int v);
      reg_sel = s; #1 v = reg_rdata;
   endtask

   task automatic finish_run;
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int v;
      m_init = 0;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      chk("R12 chan_en after reset", chan_en, 0);
      chk("R12 done after reset", done, 0);
      // program while disabled: src fixed, dst forward, wide unit
      ctl(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
      wreg(2'd0, 24'hF12345);
      rd(2'd0, v); chk("R1 src upper bits", v, 24'h012345);
      wreg(2'd1, 24'h0FFFFE);
      wreg(2'd2, 24'hAB0002);
      rd(2'd3, v); chk("R1 select 3 reads zero", v, 0);
      ctl(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
      rd(2'd2, v); chk("R6 count loaded", v, 24'h000002);
      rd(2'd1, v); chk("R6 dst working loaded", v, 24'h0FFFFE);
      wreg(2'd0, 24'h0ABCDE);
      rd(2'd0, v); chk("R2 fixed write ignored", v, 24'h012345);
      wreg(2'd1, 24'h033333);
      rd(2'd1, v); chk("R3 forward write keeps working", v, 24'h0FFFFE);
      wreg(2'd2, 24'h000005);
      rd(2'd2, v); chk("R5 reload write not live", v, 24'h000002);
      strobe(1);
      chk("R8 dst wraps", dst_addr, 20'h00000);
      chk("R7 fixed src holds", src_addr, 20'h12345);
      rd(2'd2, v); chk("R7 count down", v, 1);
      strobe(1);
      chk("R7 dst step by two", dst_addr, 20'h00002);
      strobe(1);
      chk("R9 done pulse", done, 1);
      chk("R9 enable cleared", chan_en, 0);
      @(negedge clk); #1;
      chk("R9 done one cycle", done, 0);
      rd(2'd1, v); chk("R4 disabled reads written", v, 24'h033333);
      rd(2'd2, v); chk("R7 count wraps", v, 24'h00FFFF);
      strobe(1);
      rd(2'd2, v); chk("R11 strobe while disabled", v, 24'h00FFFF);
      chk("R11 no done while disabled", done, 0);
      // repeat mode: src forward byte unit, dst fixed
      wreg(2'd0, 24'h000100);
      wreg(2'd2, 24'h000001);
      ctl(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      chk("R6 src working loaded", src_addr, 20'h00100);
      strobe(1);
      chk("R7 src step by one", src_addr, 20'h00101);
      strobe(1);
      chk("R10 done pulse", done, 1);
      chk("R10 stays enabled", chan_en, 1);
      chk("R10 src restored", src_addr, 20'h00100);
      chk("R10 fixed dst", dst_addr, 20'h33333);
      rd(2'd2, v); chk("R10 count reloaded", v, 1);
      ctl(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
      rd(2'd2, v); chk("R11 strobe with control write", v, 1);
      chk("R11 src unchanged", src_addr, 20'h00100);
      ctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      chk("R9 disabled by control", chan_en, 0);
      repeat (2) @(negedge clk);
      #1 finish_run();
   end
endmodule